// File: doc/BRIEF.md
# Register Rename Map Unit

This block translates the architectural register numbers of a stream of instructions into physical register tags. One instruction per cycle is offered on the rename port. Each instruction carries two source register numbers and, optionally, a destination register number. The block returns the physical tags that currently hold both sources. If the instruction writes a register, it also returns a fresh physical tag taken from a pool of unused registers. From then on, that fresh tag becomes the mapping for the destination.

Because every write lands in a register that no earlier instruction touches, a later writer never has to wait for an earlier reader or writer of the same architectural register. Only true producer-to-consumer ordering remains. Physical tags that the rest of the machine no longer needs come back through a release port and join the tail of the pool. When the pool runs dry, the block drops its ready signal and holds its state until a tag is returned.

Top module: `rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The pool holds tags NLOG to NPHYS-1 in ascending order, so the first allocation yields NLOG.
- R2: The pool is first-in first-out. Each accepted instruction with `in_dst_en` high takes the tag at the head of the pool.
- R3: Source tags reflect the most recent mapping of each source register, including mappings made by the instruction accepted in the previous cycle.
- R4: The lookup of sources happens before the destination mapping is updated. An instruction that reads and writes the same register receives the older tag as its source.
- R5: An instruction is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its tags appear on the outputs, with `out_valid` high, for exactly the following cycle. `out_valid` is low after reset.
- R6: When the pool is empty, `in_ready` is low. An instruction offered then is not accepted, produces no output, and leaves every mapping unchanged.
- R7: A tag presented with `rel_valid` is appended to the tail of the pool. With an otherwise empty pool, it is the tag handed to the writer accepted in the next cycle.
- R8: An accepted instruction with `in_dst_en` low consumes no tag. Its result shows `out_dst_vld` low and `out_dst_tag` zero.
- R9: Successive writers of the same architectural register receive distinct tags. A reader that follows them sees the newest tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered on the rename port |
| in_ready | output | 1 | Pool not empty; an offered instruction is accepted |
| in_dst_en | input | 1 | Instruction writes a destination register |
| in_dst | input | LW | Destination architectural register |
| in_src0 | input | LW | First source architectural register |
| in_src1 | input | LW | Second source architectural register |
| rel_valid | input | 1 | Return a physical tag to the pool |
| rel_tag | input | TW | Physical tag being returned |
| out_valid | output | 1 | Renamed result present |
| out_dst_vld | output | 1 | Result carries a newly allocated destination tag |
| out_src0_tag | output | TW | Physical tag of the first source |
| out_src1_tag | output | TW | Physical tag of the second source |
| out_dst_tag | output | TW | Newly allocated physical tag, zero when none |

## Verification
The bench first runs read-only instructions across all architectural registers. These separate the reset mapping from any allocation effect. It then runs a dependent chain: a read-modify-write of one register, followed by a reader of it, a second writer of it, and a reader of both. This chain tells the old-tag-on-self-read ordering apart from the newest-mapping forwarding and from the distinct-tag rule. Back-to-back writers drain the pool to exercise the empty stall. Releases issued during the stall, and releases issued in the same cycle as allocation, show the tail ordering of the pool and show that a stalled instruction left the map untouched.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int NLOG  = 8,
  parameter int NPHYS = 16,
  parameter int LW    = $clog2(NLOG),
  parameter int TW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_dst_en,
  input  logic [LW-1:0] in_dst,
  input  logic [LW-1:0] in_src0,
  input  logic [LW-1:0] in_src1,
  input  logic          rel_valid,
  input  logic [TW-1:0] rel_tag,
  output logic          out_valid,
  output logic          out_dst_vld,
  output logic [TW-1:0] out_src0_tag,
  output logic [TW-1:0] out_src1_tag,
  output logic [TW-1:0] out_dst_tag
);
  localparam int NFREE = NPHYS - NLOG;
  localparam int CW    = TW + 1;

  logic [TW-1:0] map_q [NLOG];
  logic [TW-1:0] pool_q [NPHYS];
  logic [TW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  wire fire  = in_valid && in_ready;
  wire alloc = fire && in_dst_en;

  assign in_ready = (cnt_q != '0);

  function automatic logic [TW-1:0] bump(input logic [TW-1:0] p);
    return (p == TW'(NPHYS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOG; i++) map_q[i] <= TW'(i);
    end else if (alloc) begin
      map_q[in_dst] <= pool_q[head_q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++)
        pool_q[i] <= (i < NFREE) ? TW'(i + NLOG) : '0;
      head_q <= '0;
      tail_q <= TW'(NFREE % NPHYS);
      cnt_q  <= CW'(NFREE);
    end else begin
      if (alloc) head_q <= bump(head_q);
      if (rel_valid) begin
        pool_q[tail_q] <= rel_tag;
        tail_q <= bump(tail_q);
      end
      cnt_q <= cnt_q + CW'(rel_valid) - CW'(alloc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_dst_vld  <= 1'b0;
      out_src0_tag <= '0;
      out_src1_tag <= '0;
      out_dst_tag  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_src0_tag <= map_q[in_src0];
        out_src1_tag <= map_q[in_src1];
        out_dst_vld  <= in_dst_en;
        out_dst_tag  <= in_dst_en ? pool_q[head_q] : '0;
      end
    end
  end

  a_r6_stall_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> !out_valid);
  a_r5_pulse_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid) && $past(in_ready));
  a_r8_nodst_keeps_pool: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_dst_en |=> cnt_q == $past(cnt_q) + CW'($past(rel_valid)));
  a_r7_release_fits: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> cnt_q < CW'(NPHYS));
  a_r8_nodst_zero_tag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dst_vld |-> out_dst_tag == '0);
  a_r2_pool_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NPHYS));
endmodule

// File: tb/sim_rename_map.sv
module sim_rename_map;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_dst_en = 1'b0, rel_valid = 1'b0;
  logic [2:0] in_dst = '0, in_src0 = '0, in_src1 = '0;
  logic [3:0] rel_tag = '0;
  logic in_ready, out_valid, out_dst_vld;
  logic [3:0] out_src0_tag, out_src1_tag, out_dst_tag;

  always #2.5 clk = ~clk;

  rename_map u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dst_en(in_dst_en), .in_dst(in_dst), .in_src0(in_src0), .in_src1(in_src1),
    .rel_valid(rel_valid), .rel_tag(rel_tag), .out_valid(out_valid),
    .out_dst_vld(out_dst_vld), .out_src0_tag(out_src0_tag),
    .out_src1_tag(out_src1_tag), .out_dst_tag(out_dst_tag));

  int checks = 0, fails = 0;
  logic [3:0] mdl_map [8];
  logic [3:0] mdl_pool [$];
  logic [12:0] expq [$];
  string tagq [$];

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // driver: one cycle of stimulus, scoreboard entry pushed when accepted
  task automatic step(input logic v, input logic de, input logic [2:0] d,
                      input logic [2:0] s0, input logic [2:0] s1,
                      input logic rv, input logic [3:0] rt, input string req);
    @(negedge clk);
    in_valid = v; in_dst_en = de; in_dst = d; in_src0 = s0; in_src1 = s1;
    rel_valid = rv; rel_tag = rt;
    if (v && in_ready) begin
      logic [3:0] nd;
      nd = '0;
      if (de) nd = mdl_pool.pop_front();
      expq.push_back({de, nd, mdl_map[s0], mdl_map[s1]});
      tagq.push_back(req);
      if (de) mdl_map[d] = nd;
    end
    if (rv) mdl_pool.push_back(rt);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 4'd0, "");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (expq.size() == 0) begin
        check(1, 0, "R5 unexpected out_valid");
      end else begin
        logic [12:0] e;
        string r;
        e = expq.pop_front();
        r = tagq.pop_front();
        check(int'(out_dst_vld), int'(e[12]), {r, " dst_vld"});
        check(int'(out_dst_tag), int'(e[11:8]), {r, " dst_tag"});
        check(int'(out_src0_tag), int'(e[7:4]), {r, " src0"});
        check(int'(out_src1_tag), int'(e[3:0]), {r, " src1"});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl_map[i] = 4'(i);
    for (int i = 8; i < 16; i++) mdl_pool.push_back(4'(i));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(int'(out_valid), 0, "R5 reset out_valid");
    check(int'(in_ready), 1, "R1 reset ready");

    // R1 / R8: identity map, reads allocate nothing
    for (int i = 0; i < 8; i += 2)
      step(1'b1, 1'b0, 3'd0, 3'(i), 3'(i + 1), 1'b0, 4'd0, "R1_R8 reset map");
    // R4: r3 <= r3 op r5 sees old tag 3, gets 8 (R2)
    step(1'b1, 1'b1, 3'd3, 3'd3, 3'd5, 1'b0, 4'd0, "R4_R2 self read");
    // R3: r4 <= r3 back-to-back reads 8
    step(1'b1, 1'b1, 3'd4, 3'd3, 3'd3, 1'b0, 4'd0, "R3 forward");
    // R9: second writer of r3
    step(1'b1, 1'b1, 3'd3, 3'd5, 3'd5, 1'b0, 4'd0, "R9 rewrite");
    step(1'b1, 1'b0, 3'd0, 3'd3, 3'd4, 1'b0, 4'd0, "R9 newest");
    idle();
    idle();
    check(int'(expq.size()), 0, "R5 all results seen");

    // drain the pool (5 left)
    for (int i = 0; i < 5; i++)
      step(1'b1, 1'b1, 3'(i), 3'd7, 3'(i), 1'b0, 4'd0, "R2 drain");
    @(negedge clk);
    in_valid = 1'b0;
    check(int'(in_ready), 0, "R6 empty ready");
    // R6: offered while empty, must be ignored
    step(1'b1, 1'b1, 3'd6, 3'd6, 3'd6, 1'b0, 4'd0, "R6 stalled");
    step(1'b1, 1'b1, 3'd6, 3'd6, 3'd6, 1'b0, 4'd0, "R6 stalled");
    check(int'(in_ready), 0, "R6 still empty");
    // R7: release during stall
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 4'd6, "");
    check(int'(out_valid), 0, "R6 no output while stalled");
    idle();
    check(int'(in_ready), 1, "R7 ready after release");
    step(1'b1, 1'b1, 3'd1, 3'd6, 3'd3, 1'b0, 4'd0, "R7_R6 reuse released");
    idle();
    check(int'(in_ready), 0, "R7 pool empty again");

    // R7: tail order with several releases, overlapping allocation
    step(1'b0, 1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 4'd2, "");
    step(1'b1, 1'b1, 3'd2, 3'd2, 3'd1, 1'b1, 4'd4, "R7 alloc with release");
    step(1'b1, 1'b0, 3'd0, 3'd2, 3'd6, 1'b1, 4'd5, "R8 nodst with release");
    step(1'b1, 1'b1, 3'd5, 3'd5, 3'd2, 1'b0, 4'd0, "R7 tail order");
    step(1'b1, 1'b1, 3'd5, 3'd5, 3'd5, 1'b0, 4'd0, "R9 again");
    idle();
    check(int'(in_ready), 0, "R2 pool consumed");
    idle();
    check(int'(expq.size()), 0, "R5 queue drained");
    finish_run();
  end
endmodule